// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of the cache misses that are still waiting for memory, so that a non-blocking cache can keep serving other requests. It has a small array of tracking entries. Each entry stands for one outstanding block and holds several waiting accesses. A waiting access records a destination tag, a word offset, a load/store flag and, for a store, the store data.

A miss whose block is not tracked yet claims a free entry and sends one memory request. A later miss to a block that is already outstanding joins that entry and does not go to memory again. Returning fill words are routed by entry number. Each word releases the accesses that wait on it, and the final word of the block releases everything that is still waiting.

Released accesses go back to the core one per cycle on the response port. A load carries the filled word and a store carries its own data, which the cache merges into the line. An entry becomes free only after its final word has arrived and its last response has left.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is in use, `rsp_valid_o`, `mreq_valid_o` and `miss_stall_o` are 0, and the first accepted miss is given entry 0.
- R2: An accepted miss to a block that no open entry tracks claims the lowest-numbered free entry. In the same cycle it raises `mreq_valid_o`, with `mreq_blk_o` equal to the miss block and `mreq_id_o` equal to that entry number.
- R3: An accepted miss to a block that an open entry already tracks is added to that entry as a new waiting access, and `mreq_valid_o` stays 0.
- R4: `miss_stall_o` is raised in the same cycle as `miss_valid_i` in two cases: the block has no open entry and every entry is in use, or the block's open entry has all its access slots taken. A stalled miss sends no memory request and never produces a response.
- R5: A non-final fill word (`fill_id_i` selects the entry, `fill_word_i` the word) releases every access of that entry waiting on that word. The response appears in the next cycle. A load returns the fill data with `rsp_store_o`=0, and a store returns its own data with `rsp_store_o`=1.
- R6: An access that joins an entry whose word has already arrived is released in the next cycle and returns the word captured earlier.
- R7: A fill with `fill_last_i`=1 releases all accesses still waiting in that entry. Released accesses leave one per cycle, ordered first by lowest entry number and then by lowest slot number, where slots are filled in arrival order.
- R8: An entry stays in use until the cycle in which its last response leaves, and a new block can claim it from the next cycle on.
- R9: A miss to a block arriving in the same cycle as that block's final fill word claims a new entry and sends a new memory request instead of joining the entry that is closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid_i | input | 1 | Miss request present |
| miss_blk_i | input | BLK_W | Block address of the miss |
| miss_word_i | input | WORD_W | Word offset inside the block |
| miss_store_i | input | 1 | 1 for a store, 0 for a load |
| miss_tag_i | input | TAG_W | Destination tag returned with the response |
| miss_wdata_i | input | DATA_W | Store data |
| miss_stall_o | output | 1 | Miss cannot be taken this cycle |
| mreq_valid_o | output | 1 | New block request to memory |
| mreq_blk_o | output | BLK_W | Block address requested |
| mreq_id_o | output | ENT_IW | Entry number that the fill must carry back |
| fill_valid_i | input | 1 | Fill word present |
| fill_id_i | input | ENT_IW | Entry the fill word belongs to |
| fill_word_i | input | WORD_W | Word offset of the fill word |
| fill_data_i | input | DATA_W | Fill word data |
| fill_last_i | input | 1 | Final word of the block |
| rsp_valid_o | output | 1 | A released access is presented |
| rsp_tag_o | output | TAG_W | Tag of the released access |
| rsp_store_o | output | 1 | Released access is a store |
| rsp_word_o | output | WORD_W | Word offset of the released access |
| rsp_data_o | output | DATA_W | Load data, or store data for a store |

## Verification
On every cycle, assertions check the following. A memory request only goes out for a miss that was accepted, and a stall only occurs while a miss is presented. At most one open entry matches a miss block. A slot is written only when one is free. An entry is claimed only while it is empty, is given up only after its final word has arrived, and holds no waiting access while it is idle. Other behaviour can only be shown by the bench's scenarios: the response order across slots and entries, the data that loads and stores return, service from a word that arrived earlier, stalled misses leaving no trace, and a miss that meets its block's final fill taking a fresh entry.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  // Index of the lowest set bit of a vector of up to 32 bits; 0 when empty.
  function automatic logic [4:0] low_index(input logic [31:0] v);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/mshr_lookup.sv
module mshr_lookup
  import mshr_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int BLK_W   = 26,
  localparam int ENT_IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_ENT-1:0]              ent_valid_i,
  input  logic [NUM_ENT-1:0]              ent_open_i,
  input  logic [NUM_ENT-1:0][BLK_W-1:0]   ent_blk_i,
  input  logic                            fill_valid_i,
  input  logic [ENT_IW-1:0]               fill_id_i,
  input  logic                            fill_last_i,
  input  logic                            miss_valid_i,
  input  logic [BLK_W-1:0]                miss_blk_i,
  output logic                            hit_o,
  output logic [ENT_IW-1:0]               hit_idx_o,
  output logic                            free_any_o,
  output logic [ENT_IW-1:0]               free_idx_o
);

  logic [NUM_ENT-1:0] match_vec;
  logic [NUM_ENT-1:0] closing_now;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
    // an entry receiving its final word this cycle no longer accepts joiners
    assign closing_now[e] = fill_valid_i && fill_last_i && (fill_id_i == ENT_IW'(e));
    assign match_vec[e]   = ent_open_i[e] && !closing_now[e] && (ent_blk_i[e] == miss_blk_i);
  end

  assign hit_o      = |match_vec;
  assign hit_idx_o  = ENT_IW'(low_index(32'(match_vec)));
  assign free_any_o = |(~ent_valid_i);
  assign free_idx_o = ENT_IW'(low_index(32'(~ent_valid_i)));

  // R3: one block is owned by at most one open entry
  assert_single_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid_i |-> $onehot0(match_vec));

endmodule

// File: rtl/mshr_entry.sv
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int BLK_W    = 26,
  parameter int WORD_W   = 2,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 6,
  parameter int NUM_SLOT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_new_i,
  input  logic [BLK_W-1:0]  alloc_blk_i,
  input  logic              slot_wr_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              wr_store_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              fill_hit_i,
  input  logic [WORD_W-1:0] fill_word_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              fill_last_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic              open_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic              has_free_slot_o,
  output logic              ready_any_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic              rsp_store_o,
  output logic [WORD_W-1:0] rsp_word_o,
  output logic [DATA_W-1:0] rsp_data_o
);

  localparam int WORDS   = 1 << WORD_W;
  localparam int SLOT_IW = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;

  logic                valid_q, closing_q;
  logic [BLK_W-1:0]    blk_q;
  logic [WORDS-1:0]    arrived_q;
  logic [DATA_W-1:0]   wbuf_q  [WORDS];
  logic [NUM_SLOT-1:0] busy_q, ready_q, store_q;
  logic [WORD_W-1:0]   sword_q [NUM_SLOT];
  logic [TAG_W-1:0]    stag_q  [NUM_SLOT];
  logic [DATA_W-1:0]   sdata_q [NUM_SLOT];

  logic [SLOT_IW-1:0]  free_idx, sel_idx;
  logic [NUM_SLOT-1:0] ready_vec, pop_mask, fill_match;
  logic                release_now;

  // word already here, or arriving on the fill port this cycle
  function automatic logic word_present(input logic [WORD_W-1:0] w);
    return arrived_q[w] || (fill_hit_i && fill_word_i == w);
  endfunction

  function automatic logic [DATA_W-1:0] word_value(input logic [WORD_W-1:0] w);
    return (fill_hit_i && fill_word_i == w) ? fill_data_i : wbuf_q[w];
  endfunction

  assign ready_vec = busy_q & ready_q;
  assign free_idx  = SLOT_IW'(low_index(32'(~busy_q)));
  assign sel_idx   = SLOT_IW'(low_index(32'(ready_vec)));

  always_comb begin
    pop_mask = '0;
    if (pop_i) pop_mask[sel_idx] = 1'b1;
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_match
    assign fill_match[s] = fill_hit_i && busy_q[s] && !ready_q[s] &&
                           (fill_last_i || sword_q[s] == fill_word_i);
  end

  // the entry lets go once closed and its last waiting access leaves
  assign release_now = valid_q && closing_q && ((busy_q & ~pop_mask) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      closing_q <= 1'b0;
      arrived_q <= '0;
      busy_q    <= '0;
      ready_q   <= '0;
    end else begin
      if (alloc_new_i) begin
        valid_q   <= 1'b1;
        closing_q <= 1'b0;
        arrived_q <= '0;
      end else begin
        if (release_now) begin
          valid_q   <= 1'b0;
          closing_q <= 1'b0;
        end else if (fill_hit_i && fill_last_i) begin
          closing_q <= 1'b1;
        end
        if (fill_hit_i) arrived_q[fill_word_i] <= 1'b1;
      end
      for (int s = 0; s < NUM_SLOT; s++) begin
        if (pop_mask[s]) begin
          busy_q[s]  <= 1'b0;
          ready_q[s] <= 1'b0;
        end else if (fill_match[s]) begin
          ready_q[s] <= 1'b1;
        end
        if (slot_wr_i && free_idx == SLOT_IW'(s)) begin
          busy_q[s]  <= 1'b1;
          ready_q[s] <= !alloc_new_i && word_present(wr_word_i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_new_i) blk_q <= alloc_blk_i;
    if (fill_hit_i) wbuf_q[fill_word_i] <= fill_data_i;
    for (int s = 0; s < NUM_SLOT; s++) begin
      if (fill_match[s] && !store_q[s]) sdata_q[s] <= word_value(sword_q[s]);
      if (slot_wr_i && free_idx == SLOT_IW'(s)) begin
        sword_q[s] <= wr_word_i;
        store_q[s] <= wr_store_i;
        stag_q[s]  <= wr_tag_i;
        sdata_q[s] <= wr_store_i ? wr_data_i : word_value(wr_word_i);
      end
    end
  end

  assign valid_o         = valid_q;
  assign open_o          = valid_q && !closing_q;
  assign blk_o           = blk_q;
  assign has_free_slot_o = |(~busy_q);
  assign ready_any_o     = |ready_vec;
  assign rsp_tag_o       = stag_q[sel_idx];
  assign rsp_store_o     = store_q[sel_idx];
  assign rsp_word_o      = sword_q[sel_idx];
  assign rsp_data_o      = sdata_q[sel_idx];

  // R4: a slot is only written when one is free
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_wr_i |-> has_free_slot_o);

  // R2: only an empty entry is claimed
  assert_claim_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_new_i |-> !valid_q);

  // R8: an entry is given up only after its final word has arrived
  assert_release_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_q) |-> $past(closing_q));

  // R8: an idle entry holds no waiting access
  assert_idle_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (busy_q == '0));

endmodule

// File: rtl/mshr_rsp_pick.sv
module mshr_rsp_pick
  import mshr_pkg::*;
#(
  parameter int NUM_ENT = 4,
  localparam int ENT_IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic [NUM_ENT-1:0] ready_i,
  output logic               any_o,
  output logic [ENT_IW-1:0]  idx_o,
  output logic [NUM_ENT-1:0] grant_o
);

  assign any_o = |ready_i;
  assign idx_o = ENT_IW'(low_index(32'(ready_i)));

  always_comb begin
    grant_o = '0;
    if (any_o) grant_o[idx_o] = 1'b1;
  end

endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
  parameter int NUM_ENT  = 4,
  parameter int NUM_SLOT = 4,
  parameter int BLK_W    = 26,
  parameter int WORD_W   = 2,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 6,
  localparam int ENT_IW  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid_i,
  input  logic [BLK_W-1:0]  miss_blk_i,
  input  logic [WORD_W-1:0] miss_word_i,
  input  logic              miss_store_i,
  input  logic [TAG_W-1:0]  miss_tag_i,
  input  logic [DATA_W-1:0] miss_wdata_i,
  output logic              miss_stall_o,
  output logic              mreq_valid_o,
  output logic [BLK_W-1:0]  mreq_blk_o,
  output logic [ENT_IW-1:0] mreq_id_o,
  input  logic              fill_valid_i,
  input  logic [ENT_IW-1:0] fill_id_i,
  input  logic [WORD_W-1:0] fill_word_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              fill_last_i,
  output logic              rsp_valid_o,
  output logic [TAG_W-1:0]  rsp_tag_o,
  output logic              rsp_store_o,
  output logic [WORD_W-1:0] rsp_word_o,
  output logic [DATA_W-1:0] rsp_data_o
);

  logic [NUM_ENT-1:0]             ent_valid, ent_open, ent_has_free, ent_ready;
  logic [NUM_ENT-1:0]             ent_alloc, ent_wr, ent_fill, ent_pop;
  logic [NUM_ENT-1:0][BLK_W-1:0]  ent_blk;
  logic [NUM_ENT-1:0][TAG_W-1:0]  ent_tag;
  logic [NUM_ENT-1:0]             ent_store;
  logic [NUM_ENT-1:0][WORD_W-1:0] ent_word;
  logic [NUM_ENT-1:0][DATA_W-1:0] ent_data;

  logic              hit, free_any, accept;
  logic [ENT_IW-1:0] hit_idx, free_idx, pick_idx;

  mshr_lookup #(.NUM_ENT(NUM_ENT), .BLK_W(BLK_W)) i_lookup (
    .clk          (clk),
    .rst_n        (rst_n),
    .ent_valid_i  (ent_valid),
    .ent_open_i   (ent_open),
    .ent_blk_i    (ent_blk),
    .fill_valid_i (fill_valid_i),
    .fill_id_i    (fill_id_i),
    .fill_last_i  (fill_last_i),
    .miss_valid_i (miss_valid_i),
    .miss_blk_i   (miss_blk_i),
    .hit_o        (hit),
    .hit_idx_o    (hit_idx),
    .free_any_o   (free_any),
    .free_idx_o   (free_idx)
  );

  assign miss_stall_o = miss_valid_i && (hit ? !ent_has_free[hit_idx] : !free_any);
  assign accept       = miss_valid_i && !miss_stall_o;
  assign mreq_valid_o = accept && !hit;
  assign mreq_blk_o   = miss_blk_i;
  assign mreq_id_o    = free_idx;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    assign ent_alloc[e] = accept && !hit && (free_idx == ENT_IW'(e));
    assign ent_wr[e]    = accept && (hit ? (hit_idx == ENT_IW'(e)) : (free_idx == ENT_IW'(e)));
    assign ent_fill[e]  = fill_valid_i && (fill_id_i == ENT_IW'(e));

    mshr_entry #(
      .BLK_W(BLK_W), .WORD_W(WORD_W), .DATA_W(DATA_W),
      .TAG_W(TAG_W), .NUM_SLOT(NUM_SLOT)
    ) i_entry (
      .clk             (clk),
      .rst_n           (rst_n),
      .alloc_new_i     (ent_alloc[e]),
      .alloc_blk_i     (miss_blk_i),
      .slot_wr_i       (ent_wr[e]),
      .wr_word_i       (miss_word_i),
      .wr_store_i      (miss_store_i),
      .wr_tag_i        (miss_tag_i),
      .wr_data_i       (miss_wdata_i),
      .fill_hit_i      (ent_fill[e]),
      .fill_word_i     (fill_word_i),
      .fill_data_i     (fill_data_i),
      .fill_last_i     (fill_last_i),
      .pop_i           (ent_pop[e]),
      .valid_o         (ent_valid[e]),
      .open_o          (ent_open[e]),
      .blk_o           (ent_blk[e]),
      .has_free_slot_o (ent_has_free[e]),
      .ready_any_o     (ent_ready[e]),
      .rsp_tag_o       (ent_tag[e]),
      .rsp_store_o     (ent_store[e]),
      .rsp_word_o      (ent_word[e]),
      .rsp_data_o      (ent_data[e])
    );
  end

  mshr_rsp_pick #(.NUM_ENT(NUM_ENT)) i_pick (
    .ready_i (ent_ready),
    .any_o   (rsp_valid_o),
    .idx_o   (pick_idx),
    .grant_o (ent_pop)
  );

  assign rsp_tag_o   = ent_tag[pick_idx];
  assign rsp_store_o = ent_store[pick_idx];
  assign rsp_word_o  = ent_word[pick_idx];
  assign rsp_data_o  = ent_data[pick_idx];

  // R2: a memory request only leaves for a miss that was taken
  assert_mreq_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid_o |-> (miss_valid_i && !miss_stall_o));

  // R4: stall is only raised against a presented miss
  assert_stall_with_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_stall_o |-> miss_valid_i);

  // R1: no response can be pending right after reset
  assert_quiet_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rsp_valid_o);

endmodule

// File: tb/test_mshr_file.sv
`timescale 1ns/1ps
module test_mshr_file;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid_i = 0;
  logic [25:0] miss_blk_i = '0;
  logic [1:0]  miss_word_i = '0;
  logic        miss_store_i = 0;
  logic [5:0]  miss_tag_i = '0;
  logic [31:0] miss_wdata_i = '0;
  logic        miss_stall_o, mreq_valid_o;
  logic [25:0] mreq_blk_o;
  logic [1:0]  mreq_id_o;
  logic        fill_valid_i = 0;
  logic [1:0]  fill_id_i = '0;
  logic [1:0]  fill_word_i = '0;
  logic [31:0] fill_data_i = '0;
  logic        fill_last_i = 0;
  logic        rsp_valid_o, rsp_store_o;
  logic [5:0]  rsp_tag_o;
  logic [1:0]  rsp_word_o;
  logic [31:0] rsp_data_o;

  int checks = 0;
  int errors = 0;
  logic       s_stall, s_mreq;
  logic [1:0] s_id;

  always #5 clk = ~clk;

  mshr_file i_mshr_file (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 0;
    miss_valid_i = 0;
    fill_valid_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic put_miss(input logic [25:0] blk, input logic [1:0] w, input logic st,
                          input logic [5:0] tag, input logic [31:0] d);
    miss_valid_i = 1; miss_blk_i = blk; miss_word_i = w;
    miss_store_i = st; miss_tag_i = tag; miss_wdata_i = d;
  endtask

  task automatic put_fill(input logic [1:0] id, input logic [1:0] w,
                          input logic [31:0] d, input logic last);
    fill_valid_i = 1; fill_id_i = id; fill_word_i = w;
    fill_data_i = d; fill_last_i = last;
  endtask

  task automatic do_miss(input logic [25:0] blk, input logic [1:0] w, input logic st,
                         input logic [5:0] tag, input logic [31:0] d);
    @(negedge clk);
    put_miss(blk, w, st, tag, d);
    #1;
    s_stall = miss_stall_o; s_mreq = mreq_valid_o; s_id = mreq_id_o;
    @(posedge clk);
    #1 miss_valid_i = 0;
  endtask

  task automatic do_fill(input logic [1:0] id, input logic [1:0] w,
                         input logic [31:0] d, input logic last);
    @(negedge clk);
    put_fill(id, w, d, last);
    @(posedge clk);
    #1 fill_valid_i = 0;
  endtask

  task automatic expect_rsp(input string req, input logic [5:0] tag,
                            input logic st, input logic [31:0] d);
    @(negedge clk);
    #1;
    chk({req, " rsp_valid"}, 64'(rsp_valid_o), 64'd1);
    chk({req, " rsp_tag"}, 64'(rsp_tag_o), 64'(tag));
    chk({req, " rsp_store"}, 64'(rsp_store_o), 64'(st));
    chk({req, " rsp_data"}, 64'(rsp_data_o), 64'(d));
  endtask

  task automatic expect_idle(input string req);
    @(negedge clk);
    #1;
    chk({req, " no response"}, 64'(rsp_valid_o), 64'd0);
  endtask

  // R1: quiet state after reset
  task automatic t_reset();
    reset_dut();
    #1;
    chk("R1 rsp_valid", 64'(rsp_valid_o), 64'd0);
    chk("R1 mreq_valid", 64'(mreq_valid_o), 64'd0);
    chk("R1 stall", 64'(miss_stall_o), 64'd0);
    do_miss(26'h0000077, 2'd0, 1'b0, 6'd1, '0);
    chk("R1 first entry", 64'(s_id), 64'd0);
  endtask

  // R2 R3 R5 R6: primary miss, joining, word-by-word service
  task automatic t_primary_join();
    reset_dut();
    @(negedge clk);
    put_miss(26'h0000123, 2'd1, 1'b0, 6'd3, '0);
    #1;
    chk("R2 mreq_valid", 64'(mreq_valid_o), 64'd1);
    chk("R2 mreq_blk", 64'(mreq_blk_o), 64'h123);
    chk("R2 mreq_id", 64'(mreq_id_o), 64'd0);
    chk("R2 stall", 64'(miss_stall_o), 64'd0);
    @(posedge clk);
    #1 miss_valid_i = 0;
    do_miss(26'h0000123, 2'd2, 1'b1, 6'd4, 32'h0000CAFE);
    chk("R3 join no mreq", 64'(s_mreq), 64'd0);
    chk("R3 join no stall", 64'(s_stall), 64'd0);
    expect_idle("R5 before fill");
    do_fill(2'd0, 2'd1, 32'h11111111, 1'b0);
    expect_rsp("R5 load", 6'd3, 1'b0, 32'h11111111);
    do_fill(2'd0, 2'd2, 32'h22222222, 1'b0);
    expect_rsp("R5 store", 6'd4, 1'b1, 32'h0000CAFE);
    do_miss(26'h0000123, 2'd1, 1'b0, 6'd5, '0);
    chk("R6 join no mreq", 64'(s_mreq), 64'd0);
    expect_rsp("R6 arrived word", 6'd5, 1'b0, 32'h11111111);
    expect_idle("R6 drained");
  endtask

  // R7 R8 R9: final word, ordering, release and reuse
  task automatic t_last_order();
    reset_dut();
    do_miss(26'h0000ABC, 2'd3, 1'b0, 6'd10, '0);
    chk("R2 entry 0", 64'(s_id), 64'd0);
    do_miss(26'h0000ABC, 2'd3, 1'b0, 6'd11, '0);
    do_miss(26'h0000ABC, 2'd0, 1'b1, 6'd12, 32'h00005A5A);
    @(negedge clk);
    put_fill(2'd0, 2'd3, 32'h33333333, 1'b1);
    put_miss(26'h0000ABC, 2'd1, 1'b0, 6'd13, '0);
    #1;
    chk("R9 new request", 64'(mreq_valid_o), 64'd1);
    chk("R9 new entry", 64'(mreq_id_o), 64'd1);
    @(posedge clk);
    #1 begin fill_valid_i = 0; miss_valid_i = 0; end
    expect_rsp("R7 slot0", 6'd10, 1'b0, 32'h33333333);
    expect_rsp("R7 slot1", 6'd11, 1'b0, 32'h33333333);
    @(negedge clk);
    put_miss(26'h0000DDD, 2'd0, 1'b0, 6'd14, '0);
    #1;
    chk("R7 remaining store tag", 64'(rsp_tag_o), 64'd12);
    chk("R7 remaining store data", 64'(rsp_data_o), 64'h5A5A);
    chk("R8 entry 0 still held", 64'(mreq_id_o), 64'd2);
    @(posedge clk);
    #1 miss_valid_i = 0;
    do_miss(26'h0000EEE, 2'd0, 1'b0, 6'd15, '0);
    chk("R8 entry 0 reused", 64'(s_id), 64'd0);
    chk("R8 reuse mreq", 64'(s_mreq), 64'd1);
    do_miss(26'h0000ABC, 2'd2, 1'b0, 6'd16, '0);
    chk("R9 joins new open entry", 64'(s_mreq), 64'd0);
    expect_idle("R7 drained");
  endtask

  // R4 R7: slot exhaustion
  task automatic t_stall_slots();
    reset_dut();
    for (int i = 0; i < 4; i++) begin
      do_miss(26'h0000B0B, 2'd0, 1'b0, 6'(20 + i), '0);
      chk("R4 slot accepted", 64'(s_stall), 64'd0);
      chk("R3 only first requests", 64'(s_mreq), 64'(i == 0));
    end
    do_miss(26'h0000B0B, 2'd0, 1'b0, 6'd24, '0);
    chk("R4 slots full stall", 64'(s_stall), 64'd1);
    chk("R4 stalled no mreq", 64'(s_mreq), 64'd0);
    do_fill(2'd0, 2'd0, 32'h77777777, 1'b1);
    for (int i = 0; i < 4; i++) begin
      expect_rsp("R7 in slot order", 6'(20 + i), 1'b0, 32'h77777777);
    end
    expect_idle("R4 stalled miss never answered");
  endtask

  // R4 R7: entry exhaustion and order across entries
  task automatic t_stall_entries();
    reset_dut();
    for (int i = 0; i < 4; i++) begin
      do_miss(26'(i + 1), 2'd0, 1'b0, 6'(30 + i), '0);
      chk("R2 lowest free entry", 64'(s_id), 64'(i));
    end
    do_miss(26'd5, 2'd0, 1'b0, 6'd34, '0);
    chk("R4 entries full stall", 64'(s_stall), 64'd1);
    chk("R4 stalled no mreq", 64'(s_mreq), 64'd0);
    do_miss(26'd2, 2'd0, 1'b0, 6'd35, '0);
    chk("R4 join still accepted", 64'(s_stall), 64'd0);
    do_fill(2'd1, 2'd0, 32'hAAAAAAAA, 1'b1);
    @(negedge clk);
    put_fill(2'd0, 2'd0, 32'hBBBBBBBB, 1'b1);
    #1;
    chk("R7 entry1 first tag", 64'(rsp_tag_o), 64'd31);
    @(posedge clk);
    #1 fill_valid_i = 0;
    expect_rsp("R7 lower entry first", 6'd30, 1'b0, 32'hBBBBBBBB);
    expect_rsp("R7 entry1 second", 6'd35, 1'b0, 32'hAAAAAAAA);
    expect_idle("R7 drained");
  endtask

  initial begin
    t_reset();
    t_primary_join();
    t_last_order();
    t_stall_slots();
    t_stall_entries();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule